// File: doc/BRIEF.md
# Suspend Modulation Duty Generator

This block throttles a processor core by pulsing an active-low suspend request. While modulation is enabled, the request is held asserted for an ON interval and released for an OFF interval, and the two alternate. Each interval is a count of 32 µs ticks. The ticks are derived from the system clock by a prescaler of `CLK_PER_TICK` cycles. The core therefore runs at a fraction OFF/(OFF+ON) of its full speed. A count change made by software takes effect only at the next phase boundary, so an interval that has already started always completes.

Two speedup timers can lift the throttling for a while. One is triggered by interrupt activity and one by video activity. An enabled activity pulse reloads its timer from a register, and the suspend request stays released until that timer has counted down to zero in 1 ms steps. A 1 ms step is `TICKS_PER_MS` ticks.

Software reaches six byte-wide registers through a plain write/read port. The port accepts a write on every cycle, so it never applies back-pressure. It returns read data combinationally for the presented address.

Top module: `throttle_duty_gen`

## Requirements
- R1: During and after reset, `susp_n` is high and every register reads as zero.
- R2: The register map is as follows. 0x94 holds the OFF count and 0x95 holds the ON count, 8 bits each. In 0x96 only bit 0 (modulation enable) is stored. In 0x80 only bits 0 (global enable), 3 (interrupt speedup enable) and 4 (video speedup enable) are stored. 0x8C holds the interrupt speedup reload and 0x8D holds the video speedup reload, 8 bits each. Unstored bits read as zero. Other addresses read as zero and ignore writes.
- R3: With modulation enabled and both counts nonzero, `susp_n` alternates between a low run of exactly ON×`CLK_PER_TICK` cycles and a high run of exactly OFF×`CLK_PER_TICK` cycles.
- R4: While the enable bit is clear, `susp_n` is never low.
- R5: With the enable bit set and an ON count of 0, `susp_n` stays high.
- R6: With the enable bit set, an OFF count of 0 and a nonzero ON count, `susp_n` stays low.
- R7: A new ON count written during a low run does not change the length of that run. The next low run uses the new count.
- R8: The interrupt speedup works only when bits 0 and 3 of 0x80 are set and the reload value is nonzero. In that case a high `irq_evt` reloads the timer, and `susp_n` is high from the second clock edge after the event until the timer has run out. The timer runs out after N−1 to N milliseconds, where N is the reload value.
- R9: The video speedup works the same way on `vid_evt`, gated by bits 0 and 4 of 0x80 and using the reload value in 0x8D.
- R10: An activity pulse has no effect on the suspend pattern when the global enable bit is clear, when the speedup's own enable bit is clear, or when its reload value is zero.
- R11: Clearing the enable bit during a low run drives `susp_n` high on the second clock edge after the write edge, and it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_evt | input | 1 | Interrupt activity indication |
| vid_evt | input | 1 | Video activity indication |
| susp_n | output | 1 | Active-low suspend request to the core |

## Verification
The assertions check on every cycle the safety rules for the suspend output. `susp_n` goes high one edge after modulation is disabled. It is held high while a speedup timer is running. It is low only when the phase engine was in its ON phase and modulation was enabled. The unstored register bits read as zero. Exact run lengths, the deferred effect of a count change, the speedup duration and the gating by the enable bits depend on counting over many cycles. Only the bench's scenarios show these, by measuring low and high runs at the output.

// File: rtl/throttle_duty_gen_pkg.sv
package throttle_duty_gen_pkg;
  localparam int REG_W = 8;

  localparam logic [7:0] ADR_PM_EN  = 8'h80;
  localparam logic [7:0] ADR_IRQ_TM = 8'h8C;
  localparam logic [7:0] ADR_VID_TM = 8'h8D;
  localparam logic [7:0] ADR_OFFCNT = 8'h94;
  localparam logic [7:0] ADR_ONCNT  = 8'h95;
  localparam logic [7:0] ADR_CFG    = 8'h96;

  localparam logic [7:0] PM_MASK  = 8'h19;
  localparam logic [7:0] CFG_MASK = 8'h01;

  localparam int PM_GLOBAL_BIT = 0;
  localparam int PM_IRQ_BIT    = 3;
  localparam int PM_VID_BIT    = 4;
  localparam int CFG_EN_BIT    = 0;

  localparam int NUM_SPD = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_ON, PH_OFF} phase_t;
endpackage

// File: rtl/throttle_duty_tick.sv
module throttle_duty_tick #(
  parameter int DIV = 6400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic pulse
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign pulse = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (en) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/throttle_duty_regs.sv
module throttle_duty_regs
  import throttle_duty_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] off_cnt,
  output logic [REG_W-1:0] on_cnt,
  output logic             mod_en,
  output logic             pm_global,
  output logic             pm_irq,
  output logic             pm_vid,
  output logic [REG_W-1:0] irq_reload,
  output logic [REG_W-1:0] vid_reload
);
  logic [REG_W-1:0] pm_q, cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_q       <= '0;
      cfg_q      <= '0;
      off_cnt    <= '0;
      on_cnt     <= '0;
      irq_reload <= '0;
      vid_reload <= '0;
    end else if (wr) begin
      case (addr)
        ADR_PM_EN:  pm_q       <= wdata & PM_MASK;
        ADR_CFG:    cfg_q      <= wdata & CFG_MASK;
        ADR_OFFCNT: off_cnt    <= wdata;
        ADR_ONCNT:  on_cnt     <= wdata;
        ADR_IRQ_TM: irq_reload <= wdata;
        ADR_VID_TM: vid_reload <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADR_PM_EN:  rdata = pm_q;
      ADR_CFG:    rdata = cfg_q;
      ADR_OFFCNT: rdata = off_cnt;
      ADR_ONCNT:  rdata = on_cnt;
      ADR_IRQ_TM: rdata = irq_reload;
      ADR_VID_TM: rdata = vid_reload;
      default:    rdata = '0;
    endcase
  end

  assign mod_en    = cfg_q[CFG_EN_BIT];
  assign pm_global = pm_q[PM_GLOBAL_BIT];
  assign pm_irq    = pm_q[PM_IRQ_BIT];
  assign pm_vid    = pm_q[PM_VID_BIT];
endmodule

// File: rtl/throttle_duty_speedup.sv
module throttle_duty_speedup #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         allow,
  input  logic [W-1:0] reload,
  input  logic         ms_pulse,
  output logic         active
);
  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (evt && allow && (reload != '0)) begin
      remain <= reload;
    end else if (ms_pulse && (remain != '0)) begin
      remain <= remain - 1'b1;
    end
  end

  assign active = (remain != '0);
endmodule

// File: rtl/throttle_duty_phase.sv
module throttle_duty_phase
  import throttle_duty_gen_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         mod_en,
  input  logic         hold,
  input  logic [W-1:0] on_cnt,
  input  logic [W-1:0] off_cnt,
  output logic         idle,
  output logic         in_on,
  output logic         assert_q
);
  phase_t       st;
  logic [W-1:0] rem;
  logic         boundary;

  assign boundary = tick && (rem <= W'(1));
  assign idle     = (st == PH_IDLE);
  assign in_on    = (st == PH_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= PH_IDLE;
      rem      <= '0;
      assert_q <= 1'b0;
    end else begin
      assert_q <= (st == PH_ON) && mod_en && !hold;
      if (!mod_en) begin
        st  <= PH_IDLE;
        rem <= '0;
      end else begin
        case (st)
          PH_IDLE: begin
            if (on_cnt != '0) begin st <= PH_ON;  rem <= on_cnt;  end
            else              begin st <= PH_OFF; rem <= off_cnt; end
          end
          PH_ON: begin
            if (boundary) begin
              if (off_cnt != '0)     begin st <= PH_OFF; rem <= off_cnt; end
              else if (on_cnt != '0) begin st <= PH_ON;  rem <= on_cnt;  end
              else                   begin st <= PH_OFF; rem <= '0;      end
            end else if (tick) begin
              rem <= rem - 1'b1;
            end
          end
          PH_OFF: begin
            if (boundary) begin
              if (on_cnt != '0) begin st <= PH_ON;  rem <= on_cnt;  end
              else              begin st <= PH_OFF; rem <= off_cnt; end
            end else if (tick) begin
              rem <= rem - 1'b1;
            end
          end
          default: begin st <= PH_IDLE; rem <= '0; end
        endcase
      end
    end
  end
endmodule

// File: rtl/throttle_duty_gen.sv
module throttle_duty_gen
  import throttle_duty_gen_pkg::*;
#(
  parameter int CLK_PER_TICK = 6400,
  parameter int TICKS_PER_MS = 31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       irq_evt,
  input  logic       vid_evt,
  output logic       susp_n
);
  logic [REG_W-1:0] off_cnt, on_cnt, irq_reload, vid_reload;
  logic mod_en, pm_global, pm_irq, pm_vid;
  logic eng_idle, eng_on, eng_assert;
  logic mod_tick, free_tick, ms_pulse;
  logic spd_any;

  logic [NUM_SPD-1:0]       spd_evt, spd_allow, spd_active;
  logic [REG_W-1:0]         spd_reload [NUM_SPD];

  throttle_duty_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .off_cnt(off_cnt), .on_cnt(on_cnt), .mod_en(mod_en),
    .pm_global(pm_global), .pm_irq(pm_irq), .pm_vid(pm_vid),
    .irq_reload(irq_reload), .vid_reload(vid_reload)
  );

  throttle_duty_tick #(.DIV(CLK_PER_TICK)) u_mod_tick (
    .clk(clk), .rst_n(rst_n), .clr(eng_idle), .en(1'b1), .pulse(mod_tick)
  );

  throttle_duty_tick #(.DIV(CLK_PER_TICK)) u_free_tick (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .en(1'b1), .pulse(free_tick)
  );

  throttle_duty_tick #(.DIV(TICKS_PER_MS)) u_ms_tick (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .en(free_tick), .pulse(ms_pulse)
  );

  assign spd_evt[0]    = irq_evt;
  assign spd_allow[0]  = pm_global && pm_irq;
  assign spd_reload[0] = irq_reload;
  assign spd_evt[1]    = vid_evt;
  assign spd_allow[1]  = pm_global && pm_vid;
  assign spd_reload[1] = vid_reload;

  for (genvar g = 0; g < NUM_SPD; g++) begin : g_spd
    throttle_duty_speedup #(.W(REG_W)) u_spd (
      .clk(clk), .rst_n(rst_n), .evt(spd_evt[g]), .allow(spd_allow[g]),
      .reload(spd_reload[g]), .ms_pulse(ms_pulse), .active(spd_active[g])
    );
  end

  assign spd_any = |spd_active;

  throttle_duty_phase #(.W(REG_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(mod_tick), .mod_en(mod_en),
    .hold(spd_any), .on_cnt(on_cnt), .off_cnt(off_cnt),
    .idle(eng_idle), .in_on(eng_on), .assert_q(eng_assert)
  );

  assign susp_n = ~eng_assert;
endmodule

// File: rtl/throttle_duty_gen_chk.sv
module throttle_duty_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mod_en,
  input logic       spd_any,
  input logic       eng_on,
  input logic       susp_n,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_rdata
);
  // R4 R11
  release_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> susp_n);

  // R8 R9
  release_during_speedup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spd_any |=> susp_n);

  // R3
  low_only_from_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !susp_n |-> ($past(eng_on) && $past(mod_en)));

  // R2
  cfg_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h96) |-> (reg_rdata[7:1] == 7'd0));

  // R2
  pm_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h80) |-> (reg_rdata[7:5] == 3'd0 && reg_rdata[2:1] == 2'd0));

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> susp_n);
endmodule

bind throttle_duty_gen throttle_duty_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .spd_any(spd_any),
  .eng_on(eng_on), .susp_n(susp_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/throttle_duty_gen_test.sv
`timescale 1ns/1ps
module throttle_duty_gen_test;
  localparam int CPT = 4;
  localparam int TPM = 8;
  localparam int MS  = CPT * TPM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq_evt = 1'b0;
  logic vid_evt = 1'b0;
  logic susp_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  throttle_duty_gen #(.CLK_PER_TICK(CPT), .TICKS_PER_MS(TPM)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_evt(irq_evt),
    .vid_evt(vid_evt), .susp_n(susp_n)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [7:0] v);
    case (a)
      8'h80: return v & 8'h19;
      8'h96: return v & 8'h01;
      8'h8C, 8'h8D, 8'h94, 8'h95: return v;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata === e, req, reg_rdata, e);
  endtask

  task automatic wait_fall();
    int g = 0;
    while (susp_n !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
    while (susp_n === 1'b1 && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic meas(output int lo, output int hi);
    lo = 0; hi = 0;
    wait_fall();
    while (susp_n === 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
    while (susp_n === 1'b1 && hi < 5000) begin hi++; @(negedge clk); end
  endtask

  task automatic hold_level(input logic lvl, input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (susp_n !== lvl) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lo, hi, on_v, off_v, seed;
    logic [7:0] v;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(susp_n === 1'b1, "R1 in reset", susp_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 after reset
    chk(susp_n === 1'b1, "R1 after reset", susp_n, 1);
    rd_chk(8'h94, 8'h00, "R1 offcnt");
    rd_chk(8'h95, 8'h00, "R1 oncnt");
    rd_chk(8'h96, 8'h00, "R1 cfg");
    rd_chk(8'h80, 8'h00, "R1 pm");

    // R2 masks and unmapped addresses
    begin
      logic [7:0] adrs [7] = '{8'h80, 8'h8C, 8'h8D, 8'h94, 8'h95, 8'h96, 8'h50};
      for (int i = 0; i < 7; i++) begin
        v = 8'($urandom) | 8'h80;
        wr(adrs[i], v);
        rd_chk(adrs[i], exp_read(adrs[i], v), "R2 readback");
        wr(adrs[i], 8'hFF);
        rd_chk(adrs[i], exp_read(adrs[i], 8'hFF), "R2 mask");
      end
    end
    wr(8'h80, 8'h00); wr(8'h8C, 8'h00); wr(8'h8D, 8'h00); wr(8'h96, 8'h00);

    // R4 disabled: never low even with counts loaded
    wr(8'h95, 8'd3); wr(8'h94, 8'd3);
    hold_level(1'b1, 60, "R4 disabled");

    // R3 random ON/OFF pairs
    wr(8'h96, 8'h01);
    for (int k = 0; k < 6; k++) begin
      on_v  = 1 + ($urandom % 20);
      off_v = 1 + ($urandom % 20);
      wr(8'h95, 8'(on_v));
      wr(8'h94, 8'(off_v));
      meas(lo, hi);
      meas(lo, hi);
      chk(lo == on_v * CPT, "R3 low run", lo, on_v * CPT);
      chk(hi == off_v * CPT, "R3 high run", hi, off_v * CPT);
    end
    // R3 directed extremes
    wr(8'h95, 8'd1); wr(8'h94, 8'd1);
    meas(lo, hi); meas(lo, hi);
    chk(lo == CPT && hi == CPT, "R3 min counts", lo, CPT);
    wr(8'h95, 8'd255); wr(8'h94, 8'd2);
    meas(lo, hi); meas(lo, hi);
    chk(lo == 255 * CPT, "R3 max on", lo, 255 * CPT);

    // R7 count change mid low run
    wr(8'h95, 8'd10); wr(8'h94, 8'd4);
    meas(lo, hi);
    wait_fall();
    lo = 0;
    repeat (3) begin lo++; @(negedge clk); end
    reg_addr = 8'h95; reg_wdata = 8'd2; reg_wr = 1'b1;
    lo++; @(negedge clk);
    reg_wr = 1'b0;
    while (susp_n === 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
    chk(lo == 10 * CPT, "R7 current run kept", lo, 10 * CPT);
    meas(lo, hi);
    chk(lo == 2 * CPT, "R7 next run new", lo, 2 * CPT);

    // R6 OFF=0
    wr(8'h95, 8'd3); wr(8'h94, 8'd0);
    repeat (40) @(negedge clk);
    hold_level(1'b0, 100, "R6 stays low");

    // R5 ON=0
    wr(8'h95, 8'd0); wr(8'h94, 8'd3);
    repeat (40) @(negedge clk);
    hold_level(1'b1, 100, "R5 stays high");

    // R8 interrupt speedup
    wr(8'h95, 8'd5); wr(8'h94, 8'd5);
    wr(8'h8C, 8'd3); wr(8'h80, 8'h09);
    wait_fall();
    irq_evt = 1'b1; @(negedge clk); irq_evt = 1'b0;
    @(negedge clk);
    hold_level(1'b1, 2 * MS - 4, "R8 held high");
    begin
      int g = 0;
      while (susp_n === 1'b1 && g < 200) begin g++; @(negedge clk); end
      chk(susp_n === 1'b0, "R8 resumes", susp_n, 0);
    end

    // R9 video speedup
    wr(8'h80, 8'h11); wr(8'h8D, 8'd2);
    wait_fall();
    vid_evt = 1'b1; @(negedge clk); vid_evt = 1'b0;
    @(negedge clk);
    hold_level(1'b1, MS - 4, "R9 held high");
    begin
      int g = 0;
      while (susp_n === 1'b1 && g < 200) begin g++; @(negedge clk); end
      chk(susp_n === 1'b0, "R9 resumes", susp_n, 0);
    end

    // R10 global off, own bit off, reload zero
    begin
      logic [7:0] pm_set [3] = '{8'h08, 8'h01, 8'h09};
      logic [7:0] rl_set [3] = '{8'd3, 8'd3, 8'd0};
      for (int c = 0; c < 3; c++) begin
        wr(8'h80, pm_set[c]); wr(8'h8C, rl_set[c]);
        meas(lo, hi);
        wait_fall();
        irq_evt = 1'b1;
        lo = 0;
        lo++; @(negedge clk);
        irq_evt = 1'b0;
        while (susp_n === 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
        chk(lo == 5 * CPT, "R10 ignored pulse", lo, 5 * CPT);
      end
    end
    wr(8'h80, 8'h00);

    // R11 disable during low run
    wr(8'h95, 8'd20); wr(8'h94, 8'd2);
    wait_fall();
    @(negedge clk);
    reg_addr = 8'h96; reg_wdata = 8'h00; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(susp_n === 1'b0, "R11 low until next edge", susp_n, 0);
    @(negedge clk);
    chk(susp_n === 1'b1, "R11 released", susp_n, 1);
    hold_level(1'b1, 100, "R11 stays high");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule